// File: doc/BRIEF.md
# Reorder Buffer with Precise Interrupts

This block keeps the results of an out-of-order core in program order until they can safely update architectural state. Each instruction that dispatches claims the slot at the tail of a circular buffer and receives that slot's index as its tag. An execution unit that finishes an instruction places the result in the slot named by the tag. The oldest slot leaves the buffer through a register-file write port only once its result is present, so the register file only changes in program order.

A dispatching instruction asks the buffer about each of its source registers. If an in-flight instruction will write that register, the buffer returns the youngest such producer: its value if the producer has finished, otherwise its tag, which the consumer can wait on. If no in-flight instruction writes the register, the answer is a miss and the consumer reads the register file.

An interrupt request empties the buffer in one cycle. The register file then holds exactly the effects of the instructions that committed before the head slot, and no effect of the head slot or any younger slot.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. `disp_ready` is 1, `cmt_valid` is 0, `lkp_hit` is 0, and `disp_tag` is 0.
- R2: Dispatched instructions receive tags in program order. The tags count up by one and wrap modulo DEPTH. `disp_tag` shows the tag that the next dispatch will receive.
- R3: With DEPTH instructions outstanding, `disp_ready` is 0. A dispatch offered in that state is ignored: the tag does not advance, and nothing it carried is ever committed or found by lookup.
- R4: A completion writes its data into the slot named by `cmpl_tag`, and never to the register file directly. `cmt_valid` stays 0 while the head slot has no result, even when younger slots have results.
- R5: Slots commit strictly oldest first, at most one per cycle. While `cmt_valid` is 1, `cmt_areg` and `cmt_data` present the head slot's destination register and result, and the head moves on at the next clock edge.
- R6: A lookup of register `lkp_areg` reports a hit for the youngest in-flight slot that writes that register. On a hit, `lkp_tag` gives that slot's tag. `lkp_ready` is 1 with `lkp_data` holding the result when the slot has completed, and 0 otherwise. If no in-flight slot writes the register, `lkp_hit` is 0.
- R7: When the slot found by a lookup is completed in that same cycle, the lookup reports `lkp_ready` 1 with the incoming `cmpl_data`.
- R8: In a cycle where `flush` is 1, `cmt_valid` is 0 and no dispatch is accepted. From the next cycle the buffer is empty, the next tag is 0, and any completion offered in the flush cycle has been discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| disp_valid | input | 1 | An instruction dispatches this cycle |
| disp_areg | input | AREG_W | Destination architectural register of the dispatching instruction |
| disp_ready | output | 1 | A free slot exists |
| disp_tag | output | IDX_W | Tag the next dispatch receives |
| cmpl_valid | input | 1 | An execution unit delivers a result |
| cmpl_tag | input | IDX_W | Slot the result belongs to |
| cmpl_data | input | DATA_W | Result value |
| cmt_valid | output | 1 | The head slot is written to the register file at this edge |
| cmt_areg | output | AREG_W | Register-file write address |
| cmt_data | output | DATA_W | Register-file write data |
| lkp_areg | input | AREG_W | Source register being looked up |
| lkp_hit | output | 1 | An in-flight slot writes the looked-up register |
| lkp_ready | output | 1 | The youngest such producer has its value |
| lkp_data | output | DATA_W | That producer's value when ready |
| lkp_tag | output | IDX_W | That producer's tag |
| flush | input | 1 | Interrupt taken: discard all in-flight slots |

## Verification
The assertions assume that execution units only complete slots that are allocated and still waiting for a result, and that each slot is completed exactly once. They also assume dispatch is never offered while the buffer is full without the ready check being honoured by the pointer logic.

The stimulus stays within these limits. It completes only tags it has handed out and not yet completed, and it drops its own record of every tag at a flush, so it never completes a slot that the flush discarded. The one dispatch offered while full is deliberate. It probes that the block ignores it, and the pointer assertions confirm that no allocation took place.

// File: rtl/rob_pkg.sv
package rob_pkg;
   // lifecycle of one buffer slot
   typedef enum logic [1:0] {
      SLOT_FREE = 2'd0,
      SLOT_WAIT = 2'd1,
      SLOT_DONE = 2'd2
   } slot_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             push_i,
   input  logic             pop_i,
   output logic [IDX_W-1:0] head_o,
   output logic [IDX_W-1:0] tail_o,
   output logic             full_o,
   output logic             empty_o
);
   // pointer carries an extra wrap bit above the slot index
   logic [IDX_W:0] head_q, tail_q;

   always_ff @(posedge clk) begin
      if (!rst_n || flush_i) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         head_q <= head_q + (IDX_W+1)'(pop_i);
         tail_q <= tail_q + (IDX_W+1)'(push_i);
      end
   end

   assign head_o  = head_q[IDX_W-1:0];
   assign tail_o  = tail_q[IDX_W-1:0];
   assign empty_o = (head_q == tail_q);
   assign full_o  = (head_q[IDX_W] != tail_q[IDX_W]) &&
                    (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]);

   // R3: never allocate past a full buffer
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);
   // R5: never retire from an empty buffer
   p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);
   // R5: a retirement moves the head by exactly one slot
   p_head_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !flush_i) |=> (head_q == $past(head_q) + 1'b1));
endmodule

// File: rtl/rob_lookup.sv
module rob_lookup #(
   parameter int DEPTH    = 8,
   parameter int IDX_W    = 3,
   parameter int AREG_W   = 5,
   parameter int DATA_W   = 32,
   parameter bit FWD_CMPL = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [IDX_W-1:0]              head_i,
   input  logic [DEPTH-1:0]              valid_i,
   input  logic [DEPTH-1:0]              done_i,
   input  logic [DEPTH-1:0][AREG_W-1:0]  areg_i,
   input  logic [DEPTH-1:0][DATA_W-1:0]  data_i,
   input  logic                          cmpl_valid_i,
   input  logic [IDX_W-1:0]              cmpl_tag_i,
   input  logic [DATA_W-1:0]             cmpl_data_i,
   input  logic [AREG_W-1:0]             query_i,
   output logic                          hit_o,
   output logic                          ready_o,
   output logic [DATA_W-1:0]             data_o,
   output logic [IDX_W-1:0]              tag_o
);
   logic              base_hit, base_rdy;
   logic [DATA_W-1:0] base_dat;
   logic [IDX_W-1:0]  base_tag;

   // walk from oldest to youngest; the last match wins
   always_comb begin
      logic [IDX_W-1:0] idx;
      base_hit = 1'b0;
      base_rdy = 1'b0;
      base_dat = '0;
      base_tag = '0;
      for (int k = 0; k < DEPTH; k++) begin
         idx = head_i + IDX_W'(k);
         if (valid_i[idx] && (areg_i[idx] == query_i)) begin
            base_hit = 1'b1;
            base_tag = idx;
            base_rdy = done_i[idx];
            base_dat = data_i[idx];
         end
      end
   end

   assign hit_o = base_hit;
   assign tag_o = base_tag;

   generate
      if (FWD_CMPL) begin : g_fwd
         logic bypass;
         assign bypass  = base_hit && !base_rdy && cmpl_valid_i &&
                          (cmpl_tag_i == base_tag);
         assign ready_o = base_rdy | bypass;
         assign data_o  = bypass ? cmpl_data_i : base_dat;
      end else begin : g_nofwd
         assign ready_o = base_rdy;
         assign data_o  = base_dat;
      end
   endgenerate

   // R6: a ready answer only ever comes with a hit
   p_ready_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> hit_o);
endmodule

// File: rtl/rob_core.sv
module rob_core #(
   parameter int DEPTH    = 8,
   parameter int AREG_W   = 5,
   parameter int DATA_W   = 32,
   parameter bit FWD_CMPL = 1'b1,
   localparam int IDX_W   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disp_valid,
   input  logic [AREG_W-1:0] disp_areg,
   output logic              disp_ready,
   output logic [IDX_W-1:0]  disp_tag,
   input  logic              cmpl_valid,
   input  logic [IDX_W-1:0]  cmpl_tag,
   input  logic [DATA_W-1:0] cmpl_data,
   output logic              cmt_valid,
   output logic [AREG_W-1:0] cmt_areg,
   output logic [DATA_W-1:0] cmt_data,
   input  logic [AREG_W-1:0] lkp_areg,
   output logic              lkp_hit,
   output logic              lkp_ready,
   output logic [DATA_W-1:0] lkp_data,
   output logic [IDX_W-1:0]  lkp_tag,
   input  logic              flush
);
   import rob_pkg::*;

   generate
      if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("rob_core: DEPTH must be a power of two, at least 2");
      end
      if (AREG_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("rob_core: register and data widths must be positive");
      end
   endgenerate

   slot_e                         state_q [DEPTH];
   logic [DEPTH-1:0][AREG_W-1:0]  areg_q;
   logic [DEPTH-1:0][DATA_W-1:0]  data_q;
   logic [DEPTH-1:0]              valid_v, done_v;

   logic [IDX_W-1:0] head, tail;
   logic             full, empty, push, pop;

   assign push       = disp_valid && !full && !flush;
   assign disp_ready = !full;
   assign disp_tag   = tail;

   assign pop       = (state_q[head] == SLOT_DONE) && !flush;
   assign cmt_valid = pop;
   assign cmt_areg  = areg_q[head];
   assign cmt_data  = data_q[head];

   rob_ptrs #(.IDX_W(IDX_W)) u_ptrs (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (flush),
      .push_i  (push),
      .pop_i   (pop),
      .head_o  (head),
      .tail_o  (tail),
      .full_o  (full),
      .empty_o (empty)
   );

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
               state_q[i] <= SLOT_FREE;
               areg_q[i]  <= '0;
               data_q[i]  <= '0;
            end else if (push && (tail == IDX_W'(i))) begin
               state_q[i] <= SLOT_WAIT;
               areg_q[i]  <= disp_areg;
            end else if (cmpl_valid && (cmpl_tag == IDX_W'(i)) &&
                         (state_q[i] == SLOT_WAIT)) begin
               state_q[i] <= SLOT_DONE;
               data_q[i]  <= cmpl_data;
            end else if (pop && (head == IDX_W'(i))) begin
               state_q[i] <= SLOT_FREE;
            end
         end
         assign valid_v[i] = (state_q[i] != SLOT_FREE);
         assign done_v[i]  = (state_q[i] == SLOT_DONE);
      end
   endgenerate

   rob_lookup #(
      .DEPTH(DEPTH), .IDX_W(IDX_W), .AREG_W(AREG_W),
      .DATA_W(DATA_W), .FWD_CMPL(FWD_CMPL)
   ) u_lookup (
      .clk          (clk),
      .rst_n        (rst_n),
      .head_i       (head),
      .valid_i      (valid_v),
      .done_i       (done_v),
      .areg_i       (areg_q),
      .data_i       (data_q),
      .cmpl_valid_i (cmpl_valid),
      .cmpl_tag_i   (cmpl_tag),
      .cmpl_data_i  (cmpl_data),
      .query_i      (lkp_areg),
      .hit_o        (lkp_hit),
      .ready_o      (lkp_ready),
      .data_o       (lkp_data),
      .tag_o        (lkp_tag)
   );

   // R4: results only arrive for allocated slots still waiting
   p_cmpl_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpl_valid && !flush) |-> (state_q[cmpl_tag] == SLOT_WAIT));
   // R3: while full and not flushed, the tag handed out stays put
   p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!disp_ready && !flush) |=> (disp_tag == $past(disp_tag)));
   // R8: the cycle after a flush nothing is in flight
   p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!cmt_valid && !lkp_hit && disp_tag == '0 && empty));
endmodule

// File: tb/tb_rob_core.sv
`timescale 1ns/1ps
module tb_rob_core;
   localparam int DEPTH  = 8;
   localparam int IDX_W  = 3;
   localparam int AREG_W = 5;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              disp_valid, disp_ready;
   logic [AREG_W-1:0] disp_areg;
   logic [IDX_W-1:0]  disp_tag;
   logic              cmpl_valid;
   logic [IDX_W-1:0]  cmpl_tag;
   logic [DATA_W-1:0] cmpl_data;
   logic              cmt_valid;
   logic [AREG_W-1:0] cmt_areg;
   logic [DATA_W-1:0] cmt_data;
   logic [AREG_W-1:0] lkp_areg;
   logic              lkp_hit, lkp_ready;
   logic [DATA_W-1:0] lkp_data;
   logic [IDX_W-1:0]  lkp_tag;
   logic              flush;

   always #4 clk = ~clk;

   rob_core #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_areg(disp_areg),
      .disp_ready(disp_ready), .disp_tag(disp_tag),
      .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_data(cmpl_data),
      .cmt_valid(cmt_valid), .cmt_areg(cmt_areg), .cmt_data(cmt_data),
      .lkp_areg(lkp_areg), .lkp_hit(lkp_hit), .lkp_ready(lkp_ready),
      .lkp_data(lkp_data), .lkp_tag(lkp_tag), .flush(flush)
   );

   typedef struct packed {
      logic [AREG_W-1:0] a;
      logic [DATA_W-1:0] d;
   } exp_t;

   exp_t        exp_q[$];
   logic [31:0] tag_data [DEPTH];
   int          model_tail = 0;
   int          n_tests = 0;
   int          n_fail = 0;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // advance to just after the next rising edge and idle the strobes
   task automatic tick();
      @(posedge clk);
      #1;
      disp_valid = 1'b0;
      cmpl_valid = 1'b0;
      flush      = 1'b0;
   endtask

   task automatic disp_one(input logic [AREG_W-1:0] a, input logic [31:0] d);
      tick();
      chk("R2", "dispatch tag", 32'(disp_tag), 32'(model_tail));
      chk("R3", "ready with room", 32'(disp_ready), 32'd1);
      disp_valid = 1'b1;
      disp_areg  = a;
      tag_data[model_tail] = d;
      exp_q.push_back('{a: a, d: d});
      model_tail = (model_tail + 1) % DEPTH;
      #3;
   endtask

   task automatic cmpl_one(input int tag);
      tick();
      cmpl_valid = 1'b1;
      cmpl_tag   = IDX_W'(tag);
      cmpl_data  = tag_data[tag];
      #3;
   endtask

   // monitor: every commit must match the oldest expected item
   always @(negedge clk) begin
      if (rst_n && cmt_valid) begin
         if (exp_q.size() == 0) begin
            chk("R5", "commit with nothing expected", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk("R5", "commit register", 32'(cmt_areg), 32'(e.a));
            chk("R4", "commit data", cmt_data, e.d);
         end
      end
   end

   initial begin
      #(8 * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; disp_valid = 1'b0; disp_areg = '0;
      cmpl_valid = 1'b0; cmpl_tag = '0; cmpl_data = '0;
      lkp_areg = 5'd1; flush = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      tick(); #3;
      chk("R1", "disp_ready", 32'(disp_ready), 32'd1);
      chk("R1", "cmt_valid", 32'(cmt_valid), 32'd0);
      chk("R1", "lkp_hit", 32'(lkp_hit), 32'd0);
      chk("R1", "disp_tag", 32'(disp_tag), 32'd0);

      // R6 youngest producer of register 1 is tag 2
      disp_one(5'd1, 32'hA000_0000);
      disp_one(5'd2, 32'hA000_0001);
      disp_one(5'd1, 32'hA000_0002);
      tick(); lkp_areg = 5'd1; #3;
      chk("R6", "hit", 32'(lkp_hit), 32'd1);
      chk("R6", "youngest tag", 32'(lkp_tag), 32'd2);
      chk("R6", "not ready", 32'(lkp_ready), 32'd0);
      chk("R4", "no commit before head done", 32'(cmt_valid), 32'd0);
      tick(); lkp_areg = 5'd7; #3;
      chk("R6", "miss", 32'(lkp_hit), 32'd0);

      // R7 same-cycle completion forwarded
      tick(); lkp_areg = 5'd1;
      cmpl_valid = 1'b1; cmpl_tag = 3'd2; cmpl_data = tag_data[2]; #3;
      chk("R7", "forward ready", 32'(lkp_ready), 32'd1);
      chk("R7", "forward data", lkp_data, 32'hA000_0002);
      chk("R4", "younger done, head not", 32'(cmt_valid), 32'd0);
      tick(); #3;
      chk("R6", "stored ready", 32'(lkp_ready), 32'd1);
      chk("R6", "stored data", lkp_data, 32'hA000_0002);

      // R4 out-of-order completion, in-order commit
      cmpl_one(1);
      cmpl_one(0);
      repeat (4) tick();
      #3;
      chk("R5", "all three committed", 32'(exp_q.size()), 32'd0);
      lkp_areg = 5'd2; #0;
      chk("R6", "committed producer no longer found", 32'(lkp_hit), 32'd0);

      // R3 fill to full (wraps the tags)
      for (int i = 0; i < DEPTH; i++) disp_one(AREG_W'(10 + i), 32'hB000_0000 + 32'(i));
      tick(); #3;
      chk("R3", "full stalls", 32'(disp_ready), 32'd0);
      chk("R3", "tag at full", 32'(disp_tag), 32'd3);
      tick(); disp_valid = 1'b1; disp_areg = 5'd30; #3;
      tick(); #3;
      chk("R3", "ignored dispatch kept tag", 32'(disp_tag), 32'd3);
      for (int i = DEPTH - 1; i >= 0; i--) cmpl_one((3 + i) % DEPTH);
      repeat (DEPTH + 2) tick();
      lkp_areg = 5'd30; #3;
      chk("R3", "ignored dispatch never entered", 32'(lkp_hit), 32'd0);
      chk("R5", "full drain committed", 32'(exp_q.size()), 32'd0);

      // R8 flush with a completed head and a same-cycle completion
      disp_one(5'd4, 32'hC000_0000);
      disp_one(5'd5, 32'hC000_0001);
      cmpl_one(3);
      tick(); flush = 1'b1;
      cmpl_valid = 1'b1; cmpl_tag = 3'd4; cmpl_data = tag_data[4];
      exp_q.delete(); model_tail = 0; #3;
      chk("R8", "no commit in flush cycle", 32'(cmt_valid), 32'd0);
      tick(); lkp_areg = 5'd5; #3;
      chk("R8", "empty after flush", 32'(cmt_valid), 32'd0);
      chk("R8", "tag reset", 32'(disp_tag), 32'd0);
      chk("R8", "flushed producer gone", 32'(lkp_hit), 32'd0);
      chk("R8", "room after flush", 32'(disp_ready), 32'd1);
      disp_one(5'd6, 32'hD000_0000);
      cmpl_one(0);
      repeat (3) tick();
      #3;
      chk("R5", "post-flush commit", 32'(exp_q.size()), 32'd0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule